// File: doc/BRIEF.md
# Gate Dead-Time Guard with Startup Inhibit

This block sits between a commutation stage and the six gate drivers of a three-phase half-bridge set. Every clock it takes a high-side and a low-side switch request for each phase. It turns them into gate enables that can never turn both switches of a phase on at the same time. Whenever a conducting switch is released, the phase passes through a dead interval with both gates low before the complementary switch may conduct.

The dead interval is a cycle count. It comes either from a configuration input or from a built-in default worth about 6 µs at the configured clock rate. A switch that is already on may stay on for as long as its request holds, so full duty is possible.

After the active-low reset/sleep input is released, all gates are held low until two conditions are met: a hold-off counter has covered about 3 ms, and the external charge-pump-ready input is high. Both are required, so whichever is met later ends the hold-off. Once the gates are enabled, that state lasts until the next reset.

Top module: `dt_gate_guard`

## Requirements
- R1: The high-side and low-side gate enables of one phase are never high in the same cycle.
- R2: When a phase moves from one conducting side to the other, both of its gates are low for max(D,1) cycles first. D is the dead count captured when the interval starts: `dead_cfg` when `use_default` is 0, and the built-in default (CLK_MHZ*DEAD_DEF_NS/1000 cycles) when `use_default` is 1.
- R3: During a dead interval, a request for the side that was last conducting turns that gate back on at the next clock edge, without waiting for the count to finish.
- R4: Releasing both requests, or asserting both at once (treated as no request), turns the conducting gate off. The phase then runs a full dead interval. From the idle state, a new request turns its gate on at the next edge.
- R5: A gate stays on for as long as its request is held, with no forced off-time.
- R6: While `rst_n` is low, all six gates are low, taking effect without waiting for a clock edge.
- R7: After `rst_n` rises, all gates stay low until the hold-off counter reaches HOLD (CLK_MHZ*HOLD_US cycles) and `cp_ready` is high, whichever comes later. If `cp_ready` is already high, a held request reaches its gate at edge HOLD+2 after release. If `cp_ready` rises later, the gate turns on at the second edge after it rises.
- R8: After the gates are enabled, dropping `cp_ready` has no effect on them.
- R9: A `dead_cfg` value of 0 behaves as a one-cycle dead interval.
- R10: A request change reaches the gate outputs at the first clock edge after it is presented. Outside dead intervals and the hold-off, there is no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset/sleep; forces gates low and restarts the hold-off |
| cp_ready | input | 1 | Gate supply ready flag; required before the gates are enabled |
| use_default | input | 1 | 1 selects the built-in dead count, 0 selects `dead_cfg` |
| dead_cfg | input | CNT_W | Programmed dead count in clock cycles |
| hs_req | input | NPH | High-side switch request per phase |
| ls_req | input | NPH | Low-side switch request per phase |
| gate_hs | output | NPH | High-side gate enable per phase |
| gate_ls | output | NPH | Low-side gate enable per phase |

## Verification
Each phase is registered once, so a request presented before edge k shows on the gates just after edge k. A dead interval of D cycles holds the gates low at samples k through k+D-1, and the new side appears at sample k+D. Enabling after reset takes two registers in series: the hold-off flag sets at edge HOLD+1, and the phase register follows one edge later. The bench drives inputs at the falling edge and samples 1 ns after each rising edge, and every expected value in its vector table and directed steps is placed at the cycle worked out this way.

// File: rtl/dt_pkg.sv
package dt_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HS   = 2'd1,
        PH_LS   = 2'd2,
        PH_DEAD = 2'd3
    } ph_state_e;

    typedef enum logic {
        SIDE_HS = 1'b0,
        SIDE_LS = 1'b1
    } side_e;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_HS   = 2'd1,
        REQ_LS   = 2'd2
    } req_e;

    // Both requests at once is illegal and is treated as no request.
    function automatic req_e decode_req(input logic hs, input logic ls);
        if (hs && !ls)      return REQ_HS;
        else if (ls && !hs) return REQ_LS;
        else                return REQ_NONE;
    endfunction

endpackage

// File: rtl/dt_hold.sv
module dt_hold #(
    parameter int HOLD_CYC = 150000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cp_ready,
    output logic armed
);
    localparam int W = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;
    localparam logic [W-1:0] LIMIT = W'(HOLD_CYC);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         armed;
    } hold_t;

    hold_t d, q;

    always_comb begin
        d = q;
        if (q.cnt != LIMIT)
            d.cnt = q.cnt + W'(1);
        if (q.cnt == LIMIT && cp_ready)
            d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign armed = q.armed;
endmodule

// File: rtl/dt_phase.sv
module dt_phase
    import dt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hs_req,
    input  logic             ls_req,
    input  logic [CNT_W-1:0] dead_len,
    output logic             gate_hs,
    output logic             gate_ls
);
    typedef struct packed {
        ph_state_e        st;
        side_e            prev;
        logic [CNT_W-1:0] cnt;
    } ph_t;

    ph_t  d, q;
    req_e req;

    always_comb begin
        req = decode_req(hs_req, ls_req);
        d   = q;
        if (!en) begin
            d.st  = PH_OFF;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                PH_OFF: begin
                    if (req == REQ_HS)      d.st = PH_HS;
                    else if (req == REQ_LS) d.st = PH_LS;
                end
                PH_HS: begin
                    if (req != REQ_HS) begin
                        d.st   = PH_DEAD;
                        d.prev = SIDE_HS;
                        d.cnt  = dead_len;
                    end
                end
                PH_LS: begin
                    if (req != REQ_LS) begin
                        d.st   = PH_DEAD;
                        d.prev = SIDE_LS;
                        d.cnt  = dead_len;
                    end
                end
                PH_DEAD: begin
                    if (req == REQ_HS && q.prev == SIDE_HS) begin
                        d.st  = PH_HS;
                        d.cnt = '0;
                    end else if (req == REQ_LS && q.prev == SIDE_LS) begin
                        d.st  = PH_LS;
                        d.cnt = '0;
                    end else if (q.cnt <= CNT_W'(1)) begin
                        d.cnt = '0;
                        if (req == REQ_HS)      d.st = PH_HS;
                        else if (req == REQ_LS) d.st = PH_LS;
                        else                    d.st = PH_OFF;
                    end else begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
                default: d.st = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: PH_OFF, prev: SIDE_HS, cnt: '0};
        else        q <= d;
    end

    assign gate_hs = (q.st == PH_HS);
    assign gate_ls = (q.st == PH_LS);
endmodule

// File: rtl/dt_gate_guard.sv
module dt_gate_guard #(
    parameter int NPH         = 3,
    parameter int CNT_W       = 16,
    parameter int CLK_MHZ     = 50,
    parameter int DEAD_DEF_NS = 6000,
    parameter int HOLD_US     = 3000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cp_ready,
    input  logic             use_default,
    input  logic [CNT_W-1:0] dead_cfg,
    input  logic [NPH-1:0]   hs_req,
    input  logic [NPH-1:0]   ls_req,
    output logic [NPH-1:0]   gate_hs,
    output logic [NPH-1:0]   gate_ls
);
    localparam int DEF_DEAD = CLK_MHZ * DEAD_DEF_NS / 1000;
    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;

    logic             gate_en;
    logic [CNT_W-1:0] dead_len;

    assign dead_len = use_default ? CNT_W'(DEF_DEAD) : dead_cfg;

    dt_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cp_ready (cp_ready),
        .armed    (gate_en)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_ph
        dt_phase #(.CNT_W(CNT_W)) u_ph (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (gate_en),
            .hs_req   (hs_req[p]),
            .ls_req   (ls_req[p]),
            .dead_len (dead_len),
            .gate_hs  (gate_hs[p]),
            .gate_ls  (gate_ls[p])
        );
    end
endmodule

// File: rtl/dt_gate_guard_chk.sv
module dt_gate_guard_chk #(
    parameter int NPH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           gate_en,
    input logic [NPH-1:0] hs_req,
    input logic [NPH-1:0] ls_req,
    input logic [NPH-1:0] gate_hs,
    input logic [NPH-1:0] gate_ls
);
    // R6
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |-> (gate_hs == '0 && gate_ls == '0));

    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> (gate_hs == '0 && gate_ls == '0));

    for (genvar p = 0; p < NPH; p++) begin : g_chk
        // R1
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hs[p] && gate_ls[p]));

        // R2
        hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_hs[p] |=> !gate_ls[p]);

        // R2
        ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gate_ls[p] |=> !gate_hs[p]);

        // R10
        hs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hs_req[p] && !ls_req[p] && gate_en && !gate_hs[p] && !gate_ls[p])
            |=> !gate_ls[p]);

        // R5
        hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_hs[p] && hs_req[p] && !ls_req[p]) |=> gate_hs[p]);
    end
endmodule

bind dt_gate_guard dt_gate_guard_chk #(.NPH(NPH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_en (gate_en),
    .hs_req  (hs_req),
    .ls_req  (ls_req),
    .gate_hs (gate_hs),
    .gate_ls (gate_ls)
);

// File: tb/tb_dt_gate_guard.sv
`timescale 1ns/1ps
module tb_dt_gate_guard;
    localparam int NPH   = 3;
    localparam int CNT_W = 8;
    localparam int HOLD  = 20;   // CLK_MHZ=1, HOLD_US=20
    localparam int DEFD  = 5;    // CLK_MHZ=1, DEAD_DEF_NS=5000

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cp_ready;
    logic             use_default;
    logic [CNT_W-1:0] dead_cfg;
    logic [NPH-1:0]   hs_req, ls_req;
    logic [NPH-1:0]   gate_hs, gate_ls;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dt_gate_guard #(
        .NPH(NPH), .CNT_W(CNT_W), .CLK_MHZ(1),
        .DEAD_DEF_NS(5000), .HOLD_US(20)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cp_ready(cp_ready),
        .use_default(use_default), .dead_cfg(dead_cfg),
        .hs_req(hs_req), .ls_req(ls_req),
        .gate_hs(gate_hs), .gate_ls(gate_ls)
    );

    // {hs, ls, use_default, exp_hs, exp_ls}; dead_cfg = 3; same on every phase
    localparam logic [4:0] VEC [24] = '{
        5'b10010, 5'b10010,                       // R10 on from idle, R5 held
        5'b01000, 5'b01000, 5'b01000, 5'b01001,   // R2 three-cycle gap
        5'b01001,
        5'b10000, 5'b01001,                       // R3 snap back to low side
        5'b00000, 5'b00000, 5'b00000, 5'b00000,   // R4 release, full interval
        5'b01001,                                 // R4 idle to on in one edge
        5'b11000, 5'b10000, 5'b10000, 5'b10010,   // R4 both asserted = none
        5'b01100, 5'b01000, 5'b01000, 5'b01000,   // R2 default count of 5
        5'b01000, 5'b01001
    };

    task automatic check(input string tag, input logic [5:0] exp);
        logic [5:0] act;
        act = {gate_hs, gate_ls};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got hs/ls=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // reset, release with cp_ready high, wait until the gates are enabled
    task automatic startup();
        @(negedge clk);
        rst_n = 1'b0;
        hs_req = '0;
        ls_req = '0;
        cp_ready = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (HOLD + 2) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cp_ready = 1'b0;
        use_default = 1'b0;
        dead_cfg = 8'd3;
        hs_req = '0;
        ls_req = '0;
        repeat (3) tick();
        check("R6 reset state", 6'b000000);

        // R7 hold-off timing with cp_ready already high
        @(negedge clk);
        hs_req = 3'b111;
        cp_ready = 1'b1;
        rst_n = 1'b1;
        for (int n = 1; n <= HOLD + 2; n++) begin
            tick();
            if (n == 1 || n == HOLD + 1) check("R7 held off", 6'b000000);
            if (n == HOLD + 2)           check("R7 enabled at HOLD+2", 6'b111000);
        end

        // R8 dropping cp_ready after enable is ignored
        @(negedge clk);
        cp_ready = 1'b0;
        repeat (4) tick();
        check("R8 cp_ready drop ignored", 6'b111000);

        // R6 asynchronous reset takes effect between edges
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R6 async off", 6'b000000);

        // R7 late cp_ready extends the hold-off
        @(negedge clk);
        rst_n = 1'b1;
        repeat (HOLD + 10) tick();
        check("R7 waits for cp_ready", 6'b000000);
        @(negedge clk);
        cp_ready = 1'b1;
        tick();
        check("R7 one edge after cp_ready", 6'b000000);
        tick();
        check("R7 two edges after cp_ready", 6'b111000);

        // vector table
        startup();
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            hs_req = {NPH{VEC[i][4]}};
            ls_req = {NPH{VEC[i][3]}};
            use_default = VEC[i][2];
            tick();
            check($sformatf("R1 R2 R3 R4 R5 R10 vector %0d", i),
                  {{NPH{VEC[i][1]}}, {NPH{VEC[i][0]}}});
        end

        // R9 zero count behaves as one cycle (phases now low side on)
        @(negedge clk);
        use_default = 1'b0;
        dead_cfg = 8'd0;
        hs_req = '1;
        ls_req = '0;
        tick();
        check("R9 gap cycle", 6'b000000);
        tick();
        check("R9 high side after one cycle", 6'b111000);

        // R2 per-phase independence with mixed requests, count 2
        @(negedge clk);
        dead_cfg = 8'd2;
        hs_req = 3'b101;
        ls_req = 3'b010;
        tick();
        check("R2 mixed gap 1", 6'b101000);
        tick();
        check("R2 mixed gap 2", 6'b101000);
        tick();
        check("R2 mixed low side on", 6'b101010);

        finish_run();
    end
endmodule